// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer

This block is a bank of identical down-counting timer channels sharing one 32-bit register port. Software writes an interval, picks a tick source and a power-of-two prescale, and enables the channel. Each counting step lowers the count by one. When a step would take the count to zero, that step is an expiry. An expiry sets the channel's pending bit. After that the channel either reloads its interval or, in one-shot mode, stops.

Tick sources are not clocks. They arrive as single-cycle enable pulses on `src_tick`, one line per source. A shared enable register and a shared pending register gate one interrupt line per channel. Pending bits are cleared by writing a one to them.

Read data is registered and appears one cycle after the address is presented.

Top module: `tmr_bank`

## Requirements
- R1: While reset is high, and after it falls, every register reads 0 and `irq` is 0.
- R2: Registers are mapped as follows; any other address reads 0.
  - 0x00 is the interrupt enable register; bit x belongs to channel x.
  - 0x04 is the pending register; bit x belongs to channel x.
  - Channel x has control at 0x10+0x10·x, interval at 0x14+0x10·x and current count at 0x18+0x10·x.
  - A write to the count register has no effect.
- R3: Control bit 0 enables counting. Control bits 3:2 pick the tick source: code k (0, 1 or 2) takes `src_tick[k]`, and code 3 never ticks.
- R4: Control bits 6:4 hold n. The channel makes one counting step on every 2^n-th selected tick, counted from the last control write.
- R5: With control bit 7 clear (continuous mode), a step at a count above 1 decrements the count. A step at a count of 0 or 1 is an expiry and loads the interval, so expiries repeat every `max(interval,1)` steps.
- R6: With control bit 7 set (one-shot mode), an expiry leaves the count at 0 and clears control bit 0.
- R7: Writing control bit 1 loads the interval into the count on the next clock edge. Bit 1 then reads 0, and no counting step happens in that cycle or in the cycle of any control write.
- R8: An expiry sets the channel's pending bit. Writing 1 to a pending bit clears it and writing 0 leaves it. An expiry wins over a clear in the same cycle.
- R9: `irq[x]` equals pending bit x AND enable bit x as they stood one cycle earlier.
- R10: While control bit 0 is clear, the count holds its value.
- R11: `bus_rdata` shows, one cycle late, the register addressed by `bus_addr` in the previous cycle, with that register's value from before that cycle's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address of register |
| bus_wdata | input | 32 | Write data |
| src_tick | input | 3 | Single-cycle tick pulses, one per source |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 3 | Per-channel interrupt, registered |

## Verification
The bench uses the default build: three channels, 32-bit counts, three tick sources and a 3-bit prescale field. With these values every source code, including the idle code 3, and the whole 1 to 128 division range can be reached. The bench keeps interval writes small, from 0 to 5. With short intervals, expiries, one-shot stops, and collisions between a pending clear and a fresh expiry happen many times within a few thousand cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_W    = 8;
  localparam int SRC_W     = 2;
  localparam int PSC_W     = 3;
  localparam int CH_STRIDE = 16;
  localparam int OFS_CTRL  = 0;
  localparam int OFS_IVL   = 4;
  localparam int OFS_CNT   = 8;
  localparam int ADR_IE    = 0;
  localparam int ADR_PEND  = 4;

  // field order follows the control word bit positions (bit 7 down to bit 0)
  typedef struct packed {
    logic             oneshot;
    logic [PSC_W-1:0] psc;
    logic [SRC_W-1:0] src;
    logic             reload;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [SRC_W-1:0] src_sel,
  input  logic [PSC_W-1:0] psc,
  input  logic [NSRC-1:0]  src_tick,
  output logic             step_tick
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] pcnt;
  logic [DIV_W:0]   mask_full;
  logic [DIV_W-1:0] mask;
  logic             sel_tick;

  always_comb begin
    sel_tick = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (src_sel == SRC_W'(i)) sel_tick = src_tick[i];
  end

  assign mask_full = ((DIV_W+1)'(1) << psc) - (DIV_W+1)'(1);
  assign mask      = mask_full[DIV_W-1:0];
  assign step_tick = sel_tick && ((pcnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr) pcnt <= '0;
    else if (sel_tick) pcnt <= pcnt + DIV_W'(1);
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW   = 32,
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctl_we,
  input  logic            ivl_we,
  input  logic [CW-1:0]   wdata,
  input  logic [NSRC-1:0] src_tick,
  output ctrl_t           ctrl_o,
  output logic [CW-1:0]   ivl_o,
  output logic [CW-1:0]   cnt_o,
  output logic            exp_o
);
  ctrl_t         ctrl_q;
  logic [CW-1:0] ivl_q, cnt_q;
  logic          ptick, step, at_end;

  tmr_prescale #(.NSRC(NSRC)) u_psc (
    .clk(clk), .rst(rst), .clr(ctl_we),
    .src_sel(ctrl_q.src), .psc(ctrl_q.psc),
    .src_tick(src_tick), .step_tick(ptick)
  );

  assign step   = ctrl_q.en && ptick && !ctrl_q.reload && !ctl_we;
  assign at_end = (cnt_q <= CW'(1));
  assign exp_o  = step && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ivl_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (ctl_we) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      else begin
        if (ctrl_q.reload) ctrl_q.reload <= 1'b0;
        if (exp_o && ctrl_q.oneshot) ctrl_q.en <= 1'b0;
      end
      if (ivl_we) ivl_q <= wdata;
      if (ctrl_q.reload) cnt_q <= ivl_q;
      else if (step) begin
        if (!at_end) cnt_q <= cnt_q - CW'(1);
        else if (ctrl_q.oneshot) cnt_q <= '0;
        else cnt_q <= ivl_q;
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign ivl_o  = ivl_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int CW   = 32,
  parameter int AW   = 8,
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [CW-1:0]   bus_wdata,
  input  logic [NSRC-1:0] src_tick,
  output logic [CW-1:0]   bus_rdata,
  output logic [NCH-1:0]  irq
);
  logic [NCH-1:0]        ie_q, pend_q, w1c;
  logic [NCH-1:0]        ch_exp, ch_en, ch_rl, ch_os, ch_cwe, ch_iwe;
  logic [NCH*CW-1:0]     ch_cnt, ch_ivl;
  logic [NCH*CTRL_W-1:0] ch_ctrl;
  logic [CW-1:0]         rd_nxt;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [AW-1:0] BASE = AW'(CH_STRIDE * (g + 1));
    ctrl_t c;
    assign ch_cwe[g] = bus_we && (bus_addr == BASE + AW'(OFS_CTRL));
    assign ch_iwe[g] = bus_we && (bus_addr == BASE + AW'(OFS_IVL));
    tmr_channel #(.CW(CW), .NSRC(NSRC)) u_ch (
      .clk(clk), .rst(rst), .ctl_we(ch_cwe[g]), .ivl_we(ch_iwe[g]),
      .wdata(bus_wdata), .src_tick(src_tick), .ctrl_o(c),
      .ivl_o(ch_ivl[g*CW +: CW]), .cnt_o(ch_cnt[g*CW +: CW]),
      .exp_o(ch_exp[g])
    );
    assign ch_ctrl[g*CTRL_W +: CTRL_W] = c;
    assign ch_en[g] = c.en;
    assign ch_rl[g] = c.reload;
    assign ch_os[g] = c.oneshot;
  end

  assign w1c = (bus_we && bus_addr == AW'(ADR_PEND)) ? bus_wdata[NCH-1:0] : '0;

  always_comb begin
    rd_nxt = '0;
    if (bus_addr == AW'(ADR_IE))   rd_nxt = CW'(ie_q);
    if (bus_addr == AW'(ADR_PEND)) rd_nxt = CW'(pend_q);
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == AW'(CH_STRIDE * (i + 1) + OFS_CTRL))
        rd_nxt = CW'(ch_ctrl[i*CTRL_W +: CTRL_W]);
      if (bus_addr == AW'(CH_STRIDE * (i + 1) + OFS_IVL))
        rd_nxt = ch_ivl[i*CW +: CW];
      if (bus_addr == AW'(CH_STRIDE * (i + 1) + OFS_CNT))
        rd_nxt = ch_cnt[i*CW +: CW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q      <= '0;
      pend_q    <= '0;
      irq       <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_we && bus_addr == AW'(ADR_IE)) ie_q <= bus_wdata[NCH-1:0];
      pend_q    <= (pend_q & ~w1c) | ch_exp;
      irq       <= pend_q & ie_q;
      bus_rdata <= rd_nxt;
    end
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int NCH = 3,
  parameter int CW  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [NCH-1:0]    irq,
  input logic [NCH-1:0]    pend,
  input logic [NCH-1:0]    ie,
  input logic [NCH-1:0]    exp_v,
  input logic [NCH-1:0]    en,
  input logic [NCH-1:0]    rl,
  input logic [NCH-1:0]    os,
  input logic [NCH-1:0]    cwe,
  input logic [NCH*CW-1:0] cnt,
  input logic [NCH*CW-1:0] ivl
);
  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq == '0 && pend == '0)); // R1

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    irq == $past(pend & ie)); // R9

  AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~$past(pend)) & ~$past(exp_v)) == '0); // R8

  for (genvar i = 0; i < NCH; i++) begin : g_a
    AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
      (!en[i] && !rl[i]) |=> $stable(cnt[i*CW +: CW])); // R10
    AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (rst)
      rl[i] |=> cnt[i*CW +: CW] == $past(ivl[i*CW +: CW])); // R7
    AST_RELOAD_SELFCLR: assert property (@(posedge clk) disable iff (rst)
      (rl[i] && !cwe[i]) |=> !rl[i]); // R7
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
      (exp_v[i] && os[i] && !cwe[i]) |=> !en[i]); // R6
  end
endmodule

bind tmr_bank tmr_bank_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .pend(pend_q), .ie(ie_q),
  .exp_v(ch_exp), .en(ch_en), .rl(ch_rl), .os(ch_os), .cwe(ch_cwe),
  .cnt(ch_cnt), .ivl(ch_ivl)
);

// File: tb/sim_tmr_bank.sv
module sim_tmr_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [2:0]  src_tick = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int    n_chk = 0, n_bad = 0;
  string cur_req = "R1";

  // reference state, built from the requirements
  logic [7:0]  m_ctrl[3];
  logic [31:0] m_ivl[3], m_cnt[3];
  logic [6:0]  m_pc[3];
  logic [2:0]  m_ie = '0, m_pend = '0, m_irq = '0;
  logic [31:0] m_rd = '0;

  tmr_bank u0 (.clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .src_tick(src_tick), .bus_rdata(bus_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mread(input logic [7:0] a);
    logic [31:0] r = '0;
    if (a == 8'h00) r = {29'd0, m_ie};
    if (a == 8'h04) r = {29'd0, m_pend};
    for (int i = 0; i < 3; i++) begin
      if (a == 8'(16*(i+1)))     r = {24'd0, m_ctrl[i]};
      if (a == 8'(16*(i+1) + 4)) r = m_ivl[i];
      if (a == 8'(16*(i+1) + 8)) r = m_cnt[i];
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'h04) return "R8";
    if (a[3:0] == 4'h8 && a >= 8'h10 && a < 8'h40) return "R5";
    if (a[3:0] == 4'h0 && a >= 8'h10 && a < 8'h40) return "R6";
    return "R2";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d, input logic [2:0] t);
    logic [7:0]  nc[3];
    logic [31:0] ni[3], nn[3];
    logic [6:0]  np[3];
    logic [2:0]  nie, npend, exps;
    bus_we = we; bus_addr = a; bus_wdata = d; src_tick = t;
    exps = '0;
    for (int i = 0; i < 3; i++) begin
      logic cwe, iwe, sel, st, ex;
      logic [6:0] msk;
      cwe = we && a == 8'(16*(i+1));
      iwe = we && a == 8'(16*(i+1) + 4);
      sel = (m_ctrl[i][3:2] == 2'd3) ? 1'b0 : t[m_ctrl[i][3:2]];
      msk = 7'((8'd1 << m_ctrl[i][6:4]) - 8'd1);
      st  = m_ctrl[i][0] && sel && ((m_pc[i] & msk) == msk) && !m_ctrl[i][1] && !cwe;
      ex  = st && (m_cnt[i] <= 1);
      exps[i] = ex;
      nn[i] = m_ctrl[i][1] ? m_ivl[i] :
              !st ? m_cnt[i] :
              !ex ? m_cnt[i] - 1 : (m_ctrl[i][7] ? 32'd0 : m_ivl[i]);
      np[i] = cwe ? 7'd0 : (sel ? m_pc[i] + 7'd1 : m_pc[i]);
      nc[i] = m_ctrl[i];
      if (cwe) nc[i] = d[7:0];
      else begin
        nc[i][1] = 1'b0;
        if (ex && m_ctrl[i][7]) nc[i][0] = 1'b0;
      end
      ni[i] = iwe ? d : m_ivl[i];
    end
    nie   = (we && a == 8'h00) ? d[2:0] : m_ie;
    npend = (m_pend & ~((we && a == 8'h04) ? d[2:0] : 3'b000)) | exps;
    m_rd  = mread(a);
    m_irq = m_pend & m_ie;
    @(posedge clk); #1;
    for (int i = 0; i < 3; i++) begin
      m_ctrl[i] = nc[i]; m_ivl[i] = ni[i]; m_cnt[i] = nn[i]; m_pc[i] = np[i];
    end
    m_ie = nie; m_pend = npend;
    check(cur_req, bus_rdata, m_rd);
    check("R9", {29'd0, irq}, {29'd0, m_irq});
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d); cyc(1'b1, a, d, 3'b000); endtask
  task automatic rd(input logic [7:0] a); cyc(1'b0, a, 32'd0, 3'b000); endtask
  task automatic run(input int n, input logic [7:0] a, input logic [2:0] t);
    for (int k = 0; k < n; k++) cyc(1'b0, a, 32'd0, t);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] alist[14];
    alist = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h18, 8'h20, 8'h24, 8'h28,
              8'h30, 8'h34, 8'h38, 8'h0C, 8'h44, 8'h18};
    for (int i = 0; i < 3; i++) begin
      m_ctrl[i] = '0; m_ivl[i] = '0; m_cnt[i] = '0; m_pc[i] = '0;
    end
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    cur_req = "R1";
    for (int a = 0; a < 64; a += 4) rd(8'(a));
    check("R1", {29'd0, irq}, 32'd0);

    cur_req = "R2";
    wr(8'h00, 32'h7); rd(8'h00);
    wr(8'h14, 32'd5); rd(8'h14);
    wr(8'h18, 32'd99); rd(8'h18);
    rd(8'h44); rd(8'h0C);

    cur_req = "R7";
    wr(8'h10, 32'h02); rd(8'h18); rd(8'h10);

    cur_req = "R5";
    wr(8'h10, 32'h05); run(14, 8'h18, 3'b010);
    cur_req = "R8"; rd(8'h04); wr(8'h04, 32'h7); rd(8'h04);

    cur_req = "R10";
    wr(8'h10, 32'h04); run(6, 8'h18, 3'b111);

    cur_req = "R3";
    wr(8'h10, 32'h0D); run(6, 8'h18, 3'b111);
    wr(8'h24, 32'd4); wr(8'h20, 32'h0B); run(10, 8'h28, 3'b100);
    run(4, 8'h28, 3'b011);

    cur_req = "R6";
    wr(8'h24, 32'd3); wr(8'h20, 32'h87); run(8, 8'h28, 3'b010);
    rd(8'h20); run(4, 8'h28, 3'b010);

    cur_req = "R4";
    wr(8'h34, 32'd2); wr(8'h30, 32'h25); run(24, 8'h38, 3'b010);
    wr(8'h30, 32'h75); run(40, 8'h38, 3'b010);

    cur_req = "R11";
    rd(8'h34); rd(8'h30); rd(8'h00);

    for (int k = 0; k < 4000; k++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic        we;
      we = ($urandom % 4) == 0;
      a  = alist[$urandom % 14];
      d  = $urandom;
      if (a[3:0] == 4'h4 && a != 8'h04) d = $urandom % 6;
      if (a[3:0] == 4'h0 && a != 8'h00) d = d & 32'h8F;
      cur_req = tag_of(a);
      cyc(we, a, d, 3'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule